// File: doc/BRIEF.md
# GPIO Register and Interrupt Unit with APB Access

This block gives software access to an eight-pin general purpose port over APB. Software can read the pin levels, set the values the pins drive, and choose which pins are outputs. Pin synchronization and edge detection happen outside the block. They arrive here as four groups of per-pin flags: level high, level low, rising edge and falling edge.

The block captures those flags in a 32-bit sticky raw status word. It gates that word with a software mask and raises one registered interrupt request when any unmasked flag is pending. Software acknowledges flags through a write-one-to-clear register. A single enable bit drives the enable input of an external clock-gating cell, and a scan test-mode input forces that enable on.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset, every register reads 0, and `drive_val`, `drive_en`, `clk_gate_en` (with `scan_mode` low) and `irq` are 0.
- R2: Every APB transfer completes with no wait states: `pready` is always 1 and `pslverr` is always 0.
- R3: A write to offset 0x0004 sets `drive_val`, and a write to offset 0x0008 sets `drive_en` (1 = output), both from `pwdata[7:0]`. Both registers read back zero-extended, and the upper write bits are dropped.
- R4: A read of offset 0x0000 returns `pin_state` zero-extended. A write to that offset changes nothing.
- R5: Raw status at offset 0xFF08 sets a bit in any cycle its flag input is 1, whatever the mask holds. Bits 7:0 are `flag_hi`, bits 15:8 are `flag_lo`, bits 23:16 are `flag_rise` and bits 31:24 are `flag_fall`, with pin n at bit n of its byte. Writes to raw status are ignored.
- R6: The mask sits at offset 0xFF00. A read of offset 0xFF04 returns raw status AND mask, and writes to 0xFF04 have no effect.
- R7: Writing to offset 0xFF0C clears each raw status bit whose write bit is 1 and leaves the rest unchanged. If a flag is 1 in the same cycle as its clear, the bit stays set. The clear register reads 0.
- R8: `irq` is the OR of all masked status bits, delayed by one register: it goes high one cycle after a masked bit becomes 1 and goes low one cycle after the last one clears.
- R9: Bit 0 of offset 0xFF10 drives `clk_gate_en` (1 = clock on). While `scan_mode` is 1, `clk_gate_en` is 1 whatever that bit holds, and the register still reads its stored value.
- R10: Reads of any other offset return 0, and writes to any other offset change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge inside the block |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always 1 |
| pslverr | output | 1 | Transfer error, always 0 |
| pin_state | input | 8 | Synchronized pin levels |
| flag_hi | input | 8 | Per-pin level-high flags |
| flag_lo | input | 8 | Per-pin level-low flags |
| flag_rise | input | 8 | Per-pin rising-edge flags |
| flag_fall | input | 8 | Per-pin falling-edge flags |
| drive_val | output | 8 | Values driven onto the pins |
| drive_en | output | 8 | Per-pin output enable |
| scan_mode | input | 1 | Scan test mode, forces the clock gate open |
| clk_gate_en | output | 1 | Enable for the external clock-gating cell |
| irq | output | 1 | Interrupt request |

## Verification
The flag-capture path is tested with a different, asymmetric pin in each of the four flag groups. A swapped byte lane or a reversed pin index then shows up as a wrong raw status word. Masked status and the interrupt line are tested with two raw bits set and only one unmasked. This separates a masked AND from a plain copy of raw status, and it checks when `irq` rises and falls relative to the mask and clear writes. The clear path is tested with a partial clear, a full clear, and a clear issued while the flag is still held high. The last case distinguishes set-wins priority from clear-wins priority.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_DIN   = 16'h0000;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 16'h0004;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 16'h0008;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 16'hFF00;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 16'hFF04;
  localparam logic [ADDR_W-1:0] OFS_RSTAT = 16'hFF08;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 16'hFF0C;
  localparam logic [ADDR_W-1:0] OFS_GATE  = 16'hFF10;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DIN,
    SEL_DOUT,
    SEL_DIR,
    SEL_MASK,
    SEL_MSTAT,
    SEL_RSTAT,
    SEL_CLR,
    SEL_GATE
  } reg_sel_e;

  typedef struct packed {
    logic dout;
    logic dir;
    logic mask;
    logic clr;
    logic gate;
  } wr_strobe_t;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_apb_decode.sv
module gpio_apb_decode
  import gpio_apb_pkg::*;
#(
  parameter int unsigned PINS = 8,
  localparam int unsigned FLAG_W = 4 * PINS
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [PINS-1:0]   din_val,
  input  logic [PINS-1:0]   dout_val,
  input  logic [PINS-1:0]   dir_val,
  input  logic [FLAG_W-1:0] mask_val,
  input  logic [FLAG_W-1:0] mstat_val,
  input  logic [FLAG_W-1:0] rstat_val,
  input  logic              gate_val,
  output wr_strobe_t        wr_stb,
  output logic [DATA_W-1:0] rdata
);

  reg_sel_e sel;
  logic     wr_access;
  logic     rd_active;

  always_comb begin
    unique case (paddr)
      OFS_DIN:   sel = SEL_DIN;
      OFS_DOUT:  sel = SEL_DOUT;
      OFS_DIR:   sel = SEL_DIR;
      OFS_MASK:  sel = SEL_MASK;
      OFS_MSTAT: sel = SEL_MSTAT;
      OFS_RSTAT: sel = SEL_RSTAT;
      OFS_CLR:   sel = SEL_CLR;
      OFS_GATE:  sel = SEL_GATE;
      default:   sel = SEL_NONE;
    endcase
  end

  assign wr_access = psel & penable & pwrite;
  assign rd_active = psel & ~pwrite;

  always_comb begin
    wr_stb      = '0;
    wr_stb.dout = wr_access & (sel == SEL_DOUT);
    wr_stb.dir  = wr_access & (sel == SEL_DIR);
    wr_stb.mask = wr_access & (sel == SEL_MASK);
    wr_stb.clr  = wr_access & (sel == SEL_CLR);
    wr_stb.gate = wr_access & (sel == SEL_GATE);
  end

  always_comb begin
    rdata = '0;
    if (rd_active) begin
      unique case (sel)
        SEL_DIN:   rdata = DATA_W'(din_val);
        SEL_DOUT:  rdata = DATA_W'(dout_val);
        SEL_DIR:   rdata = DATA_W'(dir_val);
        SEL_MASK:  rdata = DATA_W'(mask_val);
        SEL_MSTAT: rdata = DATA_W'(mstat_val);
        SEL_RSTAT: rdata = DATA_W'(rstat_val);
        SEL_GATE:  rdata = DATA_W'(gate_val);
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dout_we,
  input  logic            dir_we,
  input  logic            gate_we,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dout_q,
  output logic [PINS-1:0] dir_q,
  output logic            gate_q
);

  logic [PINS-1:0] dout_d;
  logic [PINS-1:0] dir_d;
  logic            gate_d;

  always_comb begin
    dout_d = dout_we ? wdata    : dout_q;
    dir_d  = dir_we  ? wdata    : dir_q;
    gate_d = gate_we ? wdata[0] : gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      dout_q <= dout_d;
      dir_q  <= dir_d;
      gate_q <= gate_d;
    end
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned PINS = 8,
  localparam int unsigned FLAG_W = 4 * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              clr_we,
  input  logic [FLAG_W-1:0] wdata,
  input  logic [PINS-1:0]   flag_hi,
  input  logic [PINS-1:0]   flag_lo,
  input  logic [PINS-1:0]   flag_rise,
  input  logic [PINS-1:0]   flag_fall,
  output logic [FLAG_W-1:0] mask_q,
  output logic [FLAG_W-1:0] rstat_q,
  output logic [FLAG_W-1:0] mstat,
  output logic              irq_q
);

  logic [FLAG_W-1:0] flag_vec;
  logic [FLAG_W-1:0] clr_vec;
  logic [FLAG_W-1:0] rstat_d;
  logic [FLAG_W-1:0] mask_d;
  logic              irq_d;

  // Each pin owns one bit in each of the four byte lanes.
  for (genvar p = 0; p < PINS; p++) begin : g_lane
    assign flag_vec[p]          = flag_hi[p];
    assign flag_vec[PINS+p]     = flag_lo[p];
    assign flag_vec[2*PINS+p]   = flag_rise[p];
    assign flag_vec[3*PINS+p]   = flag_fall[p];
  end

  assign clr_vec = clr_we ? wdata : '0;
  assign mstat   = rstat_q & mask_q;

  always_comb begin
    // A live flag outranks a clear in the same cycle.
    rstat_d = (rstat_q & ~clr_vec) | flag_vec;
    mask_d  = mask_we ? wdata : mask_q;
    irq_d   = |mstat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstat_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      rstat_q <= rstat_d;
      mask_q  <= mask_d;
      irq_q   <= irq_d;
    end
  end

endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [PINS-1:0]   pin_state,
  input  logic [PINS-1:0]   flag_hi,
  input  logic [PINS-1:0]   flag_lo,
  input  logic [PINS-1:0]   flag_rise,
  input  logic [PINS-1:0]   flag_fall,
  output logic [PINS-1:0]   drive_val,
  output logic [PINS-1:0]   drive_en,
  input  logic              scan_mode,
  output logic              clk_gate_en,
  output logic              irq
);

  localparam int unsigned FLAG_W = 4 * PINS;

  logic              rst_n_sync;
  wr_strobe_t        wr_stb;
  logic [PINS-1:0]   dout_q;
  logic [PINS-1:0]   dir_q;
  logic              gate_q;
  logic [FLAG_W-1:0] mask_q;
  logic [FLAG_W-1:0] rstat_q;
  logic [FLAG_W-1:0] mstat;
  logic              irq_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n_sync)
  );

  gpio_apb_decode #(.PINS(PINS)) u_dec (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .din_val   (pin_state),
    .dout_val  (dout_q),
    .dir_val   (dir_q),
    .mask_val  (mask_q),
    .mstat_val (mstat),
    .rstat_val (rstat_q),
    .gate_val  (gate_q),
    .wr_stb    (wr_stb),
    .rdata     (prdata)
  );

  gpio_port_regs #(.PINS(PINS)) u_port (
    .clk     (pclk),
    .rst_n   (rst_n_sync),
    .dout_we (wr_stb.dout),
    .dir_we  (wr_stb.dir),
    .gate_we (wr_stb.gate),
    .wdata   (pwdata[PINS-1:0]),
    .dout_q  (dout_q),
    .dir_q   (dir_q),
    .gate_q  (gate_q)
  );

  gpio_irq_status #(.PINS(PINS)) u_irq (
    .clk       (pclk),
    .rst_n     (rst_n_sync),
    .mask_we   (wr_stb.mask),
    .clr_we    (wr_stb.clr),
    .wdata     (pwdata[FLAG_W-1:0]),
    .flag_hi   (flag_hi),
    .flag_lo   (flag_lo),
    .flag_rise (flag_rise),
    .flag_fall (flag_fall),
    .mask_q    (mask_q),
    .rstat_q   (rstat_q),
    .mstat     (mstat),
    .irq_q     (irq_q)
  );

  assign pready      = 1'b1;
  assign pslverr     = 1'b0;
  assign drive_val   = dout_q;
  assign drive_en    = dir_q;
  assign clk_gate_en = gate_q | scan_mode;
  assign irq         = irq_q;

endmodule

// File: rtl/gpio_apb_ctrl_chk.sv
module gpio_apb_ctrl_chk
  import gpio_apb_pkg::*;
#(
  parameter int unsigned PINS = 8,
  localparam int unsigned FLAG_W = 4 * PINS
) (
  input logic              pclk,
  input logic              rst_n_sync,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] pwdata,
  input logic [DATA_W-1:0] prdata,
  input logic              pready,
  input logic              pslverr,
  input logic [PINS-1:0]   flag_hi,
  input logic [PINS-1:0]   flag_lo,
  input logic [PINS-1:0]   flag_rise,
  input logic [PINS-1:0]   flag_fall,
  input logic [PINS-1:0]   drive_en,
  input logic [PINS-1:0]   drive_val,
  input logic              scan_mode,
  input logic              clk_gate_en,
  input logic              irq,
  input logic [FLAG_W-1:0] rstat_q,
  input logic [FLAG_W-1:0] mask_q
);

  logic [FLAG_W-1:0] flags_all;
  logic              wr_acc;
  logic              mapped;

  assign flags_all = {flag_fall, flag_rise, flag_lo, flag_hi};
  assign wr_acc    = psel && penable && pwrite;
  assign mapped    = (paddr == OFS_DIN)   || (paddr == OFS_DOUT) ||
                     (paddr == OFS_DIR)   || (paddr == OFS_MASK) ||
                     (paddr == OFS_MSTAT) || (paddr == OFS_RSTAT) ||
                     (paddr == OFS_CLR)   || (paddr == OFS_GATE);

  // R2
  zero_wait_chk: assert property (@(posedge pclk) disable iff (!rst_n_sync)
    pready && !pslverr);

  // R3
  dir_write_chk: assert property (@(posedge pclk) disable iff (!rst_n_sync)
    (wr_acc && paddr == OFS_DIR) |=> (drive_en == $past(pwdata[PINS-1:0])));

  // R6
  mstat_read_chk: assert property (@(posedge pclk) disable iff (!rst_n_sync)
    (psel && !pwrite && paddr == OFS_MSTAT) |-> (prdata == DATA_W'(rstat_q & mask_q)));

  // R7
  set_wins_chk: assert property (@(posedge pclk) disable iff (!rst_n_sync)
    (|flags_all) |=> ((rstat_q & $past(flags_all)) == $past(flags_all)));

  // R8
  irq_src_chk: assert property (@(posedge pclk) disable iff (!rst_n_sync)
    irq |-> $past(|(rstat_q & mask_q)));

  // R9
  scan_gate_chk: assert property (@(posedge pclk) disable iff (!rst_n_sync)
    scan_mode |-> clk_gate_en);

  // R10
  unmapped_wr_chk: assert property (@(posedge pclk) disable iff (!rst_n_sync)
    (wr_acc && !mapped) |=> ($stable(mask_q) && $stable(drive_val) && $stable(drive_en)));

endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_chk #(.PINS(PINS)) u_chk (
  .pclk        (pclk),
  .rst_n_sync  (rst_n_sync),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .prdata      (prdata),
  .pready      (pready),
  .pslverr     (pslverr),
  .flag_hi     (flag_hi),
  .flag_lo     (flag_lo),
  .flag_rise   (flag_rise),
  .flag_fall   (flag_fall),
  .drive_en    (drive_en),
  .drive_val   (drive_val),
  .scan_mode   (scan_mode),
  .clk_gate_en (clk_gate_en),
  .irq         (irq),
  .rstat_q     (rstat_q),
  .mask_q      (mask_q)
);

// File: tb/gpio_apb_ctrl_test.sv
module gpio_apb_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        pclk;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [15:0] paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  pin_state, flag_hi, flag_lo, flag_rise, flag_fall;
  logic [7:0]  drive_val, drive_en;
  logic        scan_mode, clk_gate_en, irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  gpio_apb_ctrl #(.PINS(8)) uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pin_state(pin_state),
    .flag_hi(flag_hi), .flag_lo(flag_lo), .flag_rise(flag_rise),
    .flag_fall(flag_fall), .drive_val(drive_val), .drive_en(drive_en),
    .scan_mode(scan_mode), .clk_gate_en(clk_gate_en), .irq(irq)
  );

  initial pclk = 1'b0;
  always #(CLK_PERIOD/2) pclk = ~pclk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apb_write(logic [15:0] a, logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(logic [15:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1 d = prdata;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic pulse_flags(logic [7:0] h, logic [7:0] l, logic [7:0] r, logic [7:0] f);
    @(negedge pclk);
    flag_hi = h; flag_lo = l; flag_rise = r; flag_fall = f;
    @(negedge pclk);
    flag_hi = '0; flag_lo = '0; flag_rise = '0; flag_fall = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    presetn = 1'b0;
    repeat (3) @(negedge pclk);
    check("R1", "drive_val in reset", {24'h0, drive_val}, 32'h0);
    check("R1", "irq in reset", {31'h0, irq}, 32'h0);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);
    check("R1", "drive_en after reset", {24'h0, drive_en}, 32'h0);
    check("R1", "clk_gate_en after reset", {31'h0, clk_gate_en}, 32'h0);
    apb_read(16'h0004, v); check("R1", "data-out reset", v, 32'h0);
    apb_read(16'h0008, v); check("R1", "direction reset", v, 32'h0);
    apb_read(16'hFF00, v); check("R1", "mask reset", v, 32'h0);
    apb_read(16'hFF08, v); check("R1", "raw status reset", v, 32'h0);
    apb_read(16'hFF10, v); check("R1", "gate reset", v, 32'h0);
  endtask

  task automatic t_wait_states();
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = 16'h0000; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    check("R2", "pready in access", {31'h0, pready}, 32'h1);
    check("R2", "pslverr in access", {31'h0, pslverr}, 32'h0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic t_port_regs();
    logic [31:0] v;
    apb_write(16'h0004, 32'hFFFF_FF3C);
    check("R3", "drive_val port", {24'h0, drive_val}, 32'h3C);
    apb_write(16'h0008, 32'h0000_00F0);
    check("R3", "drive_en port", {24'h0, drive_en}, 32'hF0);
    apb_read(16'h0004, v); check("R3", "data-out readback", v, 32'h3C);
    apb_read(16'h0008, v); check("R3", "direction readback", v, 32'hF0);
  endtask

  task automatic t_data_in();
    logic [31:0] v;
    pin_state = 8'hA5;
    apb_read(16'h0000, v); check("R4", "data-in A5", v, 32'hA5);
    apb_write(16'h0000, 32'hFFFF_FFFF);
    check("R4", "data-in write leaves drive_val", {24'h0, drive_val}, 32'h3C);
    pin_state = 8'h5A;
    apb_read(16'h0000, v); check("R4", "data-in 5A", v, 32'h5A);
  endtask

  task automatic t_flag_layout();
    logic [31:0] v;
    pulse_flags(8'h01, 8'h02, 8'h04, 8'h80);
    apb_read(16'hFF08, v); check("R5", "raw status layout", v, 32'h8004_0201);
    check("R5", "masked flags leave irq low", {31'h0, irq}, 32'h0);
    apb_write(16'hFF08, 32'h0);
    apb_read(16'hFF08, v); check("R5", "raw status write ignored", v, 32'h8004_0201);
    apb_write(16'hFF0C, 32'hFFFF_FFFF);
    apb_read(16'hFF08, v); check("R7", "full clear", v, 32'h0);
  endtask

  task automatic t_mask_irq();
    logic [31:0] v;
    pulse_flags(8'h01, 8'h01, 8'h00, 8'h00);
    apb_write(16'hFF00, 32'h0000_0100);
    check("R8", "irq one cycle after mask write", {31'h0, irq}, 32'h0);
    @(negedge pclk);
    check("R8", "irq raised", {31'h0, irq}, 32'h1);
    apb_read(16'hFF04, v); check("R6", "masked status", v, 32'h0000_0100);
    apb_write(16'hFF04, 32'h0);
    apb_read(16'hFF04, v); check("R6", "masked status write ignored", v, 32'h0000_0100);
    apb_write(16'hFF0C, 32'h0000_0001);
    apb_read(16'hFF08, v); check("R7", "partial clear", v, 32'h0000_0100);
    check("R8", "irq held by unmasked bit", {31'h0, irq}, 32'h1);
    apb_write(16'hFF0C, 32'h0000_0100);
    check("R8", "irq still high after clear edge", {31'h0, irq}, 32'h1);
    @(negedge pclk);
    check("R8", "irq dropped", {31'h0, irq}, 32'h0);
    apb_read(16'hFF0C, v); check("R7", "clear reads zero", v, 32'h0);
    apb_write(16'hFF00, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    @(negedge pclk);
    flag_hi = 8'h08;
    apb_write(16'hFF0C, 32'h0000_0008);
    apb_read(16'hFF08, v); check("R7", "set wins over clear", v, 32'h0000_0008);
    flag_hi = 8'h00;
    apb_write(16'hFF0C, 32'h0000_0008);
    apb_read(16'hFF08, v); check("R7", "clear after release", v, 32'h0);
  endtask

  task automatic t_gate();
    logic [31:0] v;
    apb_write(16'hFF10, 32'h1);
    check("R9", "gate on", {31'h0, clk_gate_en}, 32'h1);
    apb_write(16'hFF10, 32'h0);
    check("R9", "gate off", {31'h0, clk_gate_en}, 32'h0);
    scan_mode = 1'b1;
    @(negedge pclk);
    check("R9", "scan forces gate", {31'h0, clk_gate_en}, 32'h1);
    apb_read(16'hFF10, v); check("R9", "gate reg under scan", v, 32'h0);
    scan_mode = 1'b0;
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    apb_write(16'h000C, 32'hFFFF_FFFF);
    apb_write(16'hFF01, 32'hFFFF_FFFF);
    apb_write(16'hFF14, 32'hFFFF_FFFF);
    apb_read(16'hFF00, v); check("R10", "mask untouched", v, 32'h0);
    apb_read(16'h0004, v); check("R10", "data-out untouched", v, 32'h3C);
    apb_read(16'h0008, v); check("R10", "direction untouched", v, 32'hF0);
    apb_read(16'hFF10, v); check("R10", "gate untouched", v, 32'h0);
    apb_read(16'h000C, v); check("R10", "unmapped read", v, 32'h0);
    apb_read(16'h8000, v); check("R10", "far unmapped read", v, 32'h0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge pclk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    pin_state = '0; flag_hi = '0; flag_lo = '0; flag_rise = '0; flag_fall = '0;
    scan_mode = 1'b0;
    t_reset();
    t_wait_states();
    t_port_regs();
    t_data_in();
    t_flag_layout();
    t_mask_irq();
    t_set_wins();
    t_gate();
    t_unmapped();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule